// File: doc/BRIEF.md
# Self-Healing Maintenance Controller

This controller schedules on-chip thermal repair for a set of logic or memory regions. Each region has an idle flag, an aging-monitor flag and a usage strobe. A poll timer periodically marks regions as pending repair. A region becomes pending when its aging monitor reports degradation or when its usage count has reached the repair interval. At most one region is repaired at a time, because there is a single spare redundancy region. Pending regions are served in round-robin order, and a region is picked only while it is idle.

A repair runs as a fixed sequence. The controller first asks an external data mover to save the region into redundancy and waits for that copy to finish. It then drives the heater enable for a pulse whose length depends on the region kind. After the pulse it asks the mover to copy the data back, and only then returns the region to service. For non-volatile regions the heat pulse comes as part of an erase, so an erase strobe accompanies the heater. The heater is gated by a temperature-safe input at all times. If that input drops during a pulse, the pulse is cut at once and the region is flagged as faulted. The restore still runs, and the region stays pending so that it is repaired again.

Top module: `heal_maint_ctrl`

## Requirements
- R1: The aging inputs and usage limits are sampled on a poll tick every POLL_CYC cycles. A region is never scheduled without a trigger, and an idle region with a raised aging flag sees copy_req_o within POLL_CYC+3 cycles.
- R2: A region is selected for repair only while its region_idle_i bit is 1. A pending region that is not idle waits, and is served once it becomes idle.
- R3: copy_req_o stays high until copy_done_i is seen. heat_en_o is never high before copy_done_i has been received for the current repair.
- R4: When the heat pulse ends, restore_req_o goes high and stays high until restore_done_i. Only after that does the controller return to idle with busy_o low.
- R5: Each usage strobe on use_i[i] counts toward REPAIR_INT (default 10). At REPAIR_INT strobes the region is scheduled. A successful repair clears the count, so 9 further strobes do not schedule it.
- R6: The heat pulse lasts HEAT_LOGIC cycles (default 6) for a logic region (kind 0) and HEAT_MEM cycles (default 3) for a dynamic-memory (kind 1) or non-volatile (kind 2) region. Kinds come from KIND_MAP, 2 bits per region, with region i at bits [2i+1:2i]. The default map gives region 0 kind 0, regions 1 and 2 kind 1, and region 3 kind 2.
- R7: erase_en_o is high together with heat_en_o only when the region under repair is non-volatile (kind 2), and is otherwise low.
- R8: heat_en_o is high only while temp_ok_i is 1. If temp_ok_i drops during a pulse, heat_en_o falls in the same cycle and fault_o for that region is set. The restore still runs, the region stays pending and is repaired again, and a later successful repair clears fault_o.
- R9: At most one of copy_req_o, heat_en_o and restore_req_o is high at a time. Regions that stay pending together are served in rotation, beginning after the region served last.
- R10: busy_o is high in every controller state except idle. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| region_idle_i | input | N_REGIONS | Region i is idle and may be repaired |
| aging_i | input | N_REGIONS | Aging monitor reports degradation of region i |
| use_i | input | N_REGIONS | One usage (write) event on region i |
| temp_ok_i | input | 1 | Temperature sensor reports a safe condition |
| copy_req_o | output | 1 | Request to save the selected region into redundancy |
| copy_done_i | input | 1 | Save to redundancy finished |
| restore_req_o | output | 1 | Request to copy redundancy back into the region |
| restore_done_i | input | 1 | Restore finished |
| region_o | output | clog2(N_REGIONS) | Index of the region under repair |
| heat_en_o | output | 1 | Heater enable for the selected region |
| erase_en_o | output | 1 | Erase strobe that carries the heat pulse for non-volatile regions |
| busy_o | output | 1 | Controller is not idle |
| fault_o | output | N_REGIONS | Last repair of region i was cut short by temperature |

## Verification
The hardest case to reach from the ports is a temperature drop in the middle of a pulse, followed by the automatic retry of the same region. The bench models the data mover and the sensor. It lowers temp_ok_i at a chosen pulse cycle, checks in that same cycle that the heater is off, completes the restore, and then serves the retry with a full-length pulse. Round-robin order is exposed by holding two aging flags high across three repairs, so that both regions are re-pended on every poll.

// File: rtl/heal_pkg.sv
// Package: shared types for the self-healing maintenance controller.
// Assumes: region kind codes are 2 bits wide, as packed into KIND_MAP.
package heal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_COPY,
        ST_HEAT,
        ST_RESTORE,
        ST_DONE
    } heal_state_t;

    localparam logic [1:0] KIND_LOGIC = 2'd0;
    localparam logic [1:0] KIND_DRAM  = 2'd1;
    localparam logic [1:0] KIND_NVM   = 2'd2;
endpackage

// File: rtl/heal_usage_ctr.sv
// Module: saturating usage counter for one region.
// Counts usage strobes up to INTERVAL and holds there until cleared.
// Assumes: clr_i has priority over use_i.
module heal_usage_ctr #(
    parameter int INTERVAL = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_i,
    input  logic clr_i,
    output logic at_limit_o
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;

    // Count usage events, saturate at the interval, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr_i) begin
            cnt <= '0;
        end else if (use_i && (cnt != CW'(INTERVAL))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_limit_o = (cnt == CW'(INTERVAL));
endmodule

// File: rtl/heal_rr_arb.sv
// Module: combinational round-robin picker.
// Searches the request vector starting at the position after last_i.
// Assumes: last_i < N.
module heal_rr_arb #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the farthest candidate down so the nearest request wins.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int p;
            p = (int'(last_i) + 1 + k) % N;
            if (req_i[p]) begin
                valid_o = 1'b1;
                idx_o   = IW'(p);
            end
        end
    end
endmodule

// File: rtl/heal_pulse_timer.sv
// Module: heat pulse timer.
// Counts while run_i is high. expire_o marks the last cycle of a pulse of len_i cycles.
// Assumes: len_i >= 1 and stays stable while run_i is high.
module heal_pulse_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             expire_o
);
    logic [LEN_W-1:0] cnt;

    // Advance while running, restart from zero whenever stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire_o = run_i && (cnt == len_i - 1'b1);
endmodule

// File: rtl/heal_maint_ctrl.sv
// Module: self-healing maintenance controller (top).
// Polls regions and marks them pending from aging flags or usage limits. It picks one
// idle pending region in round-robin order, then sequences save, heat pulse and restore.
// Assumes: one redundancy region, an external data mover that answers each
// request with a one-cycle done strobe, and a temperature sensor input.
module heal_maint_ctrl
    import heal_pkg::*;
#(
    parameter int N_REGIONS  = 4,
    parameter int POLL_CYC   = 8,
    parameter int REPAIR_INT = 10,
    parameter int HEAT_LOGIC = 6,
    parameter int HEAT_MEM   = 3,
    parameter logic [2*N_REGIONS-1:0] KIND_MAP = 8'b10_01_01_00,
    localparam int IW = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_REGIONS-1:0] region_idle_i,
    input  logic [N_REGIONS-1:0] aging_i,
    input  logic [N_REGIONS-1:0] use_i,
    input  logic                 temp_ok_i,
    output logic                 copy_req_o,
    input  logic                 copy_done_i,
    output logic                 restore_req_o,
    input  logic                 restore_done_i,
    output logic [IW-1:0]        region_o,
    output logic                 heat_en_o,
    output logic                 erase_en_o,
    output logic                 busy_o,
    output logic [N_REGIONS-1:0] fault_o
);
    localparam int HEAT_MAX = (HEAT_LOGIC > HEAT_MEM) ? HEAT_LOGIC : HEAT_MEM;
    localparam int LEN_W    = $clog2(HEAT_MAX + 1);
    localparam int PW       = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;

    heal_state_t          state, state_nx;
    logic [PW-1:0]        poll_cnt;
    logic                 poll_tick;
    logic [N_REGIONS-1:0] pend;
    logic [N_REGIONS-1:0] at_limit;
    logic [N_REGIONS-1:0] clr_use;
    logic [IW-1:0]        sel, last;
    logic                 arb_valid;
    logic [IW-1:0]        arb_idx;
    logic                 aborted;
    logic                 abort_now;
    logic                 done_ok;
    logic [1:0]           sel_kind;
    logic [LEN_W-1:0]     heat_len;
    logic                 heat_expire;
    logic                 in_heat;

    // Poll timer: one tick every POLL_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || poll_tick) begin
            poll_cnt <= '0;
        end else begin
            poll_cnt <= poll_cnt + 1'b1;
        end
    end
    assign poll_tick = (poll_cnt == PW'(POLL_CYC - 1));

    // One usage counter per region, cleared by a successful repair.
    for (genvar g = 0; g < N_REGIONS; g++) begin : g_use
        assign clr_use[g] = done_ok && (sel == IW'(g));
        heal_usage_ctr #(.INTERVAL(REPAIR_INT)) u_use (
            .clk        (clk),
            .rst_n      (rst_n),
            .use_i      (use_i[g]),
            .clr_i      (clr_use[g]),
            .at_limit_o (at_limit[g])
        );
    end

    // Pending flags: set on a poll tick from a trigger, cleared on successful repair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            for (int i = 0; i < N_REGIONS; i++) begin
                if (clr_use[i]) begin
                    pend[i] <= 1'b0;
                end else if (poll_tick && (aging_i[i] || at_limit[i])) begin
                    pend[i] <= 1'b1;
                end
            end
        end
    end

    heal_rr_arb #(.N(N_REGIONS), .IW(IW)) u_arb (
        .req_i   (pend & region_idle_i),
        .last_i  (last),
        .valid_o (arb_valid),
        .idx_o   (arb_idx)
    );

    assign sel_kind = KIND_MAP[{sel, 1'b0} +: 2];
    assign heat_len = (sel_kind == KIND_LOGIC) ? LEN_W'(HEAT_LOGIC) : LEN_W'(HEAT_MEM);
    assign in_heat  = (state == ST_HEAT);

    heal_pulse_timer #(.LEN_W(LEN_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (in_heat && temp_ok_i),
        .len_i    (heat_len),
        .expire_o (heat_expire)
    );

    assign abort_now = in_heat && !temp_ok_i;
    assign done_ok   = (state == ST_DONE) && !aborted;

    // Next-state logic of the repair sequence.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:    if (|(pend & region_idle_i)) state_nx = ST_SELECT;
            ST_SELECT:  state_nx = arb_valid ? ST_COPY : ST_IDLE;
            ST_COPY:    if (copy_done_i) state_nx = ST_HEAT;
            ST_HEAT:    if (abort_now || heat_expire) state_nx = ST_RESTORE;
            ST_RESTORE: if (restore_done_i) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Selected region and round-robin pointer, captured on a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel  <= '0;
            last <= IW'(N_REGIONS - 1);
        end else if ((state == ST_SELECT) && arb_valid) begin
            sel  <= arb_idx;
            last <= arb_idx;
        end
    end

    // Abort flag for the current repair.
    always_ff @(posedge clk) begin
        if (!rst_n || (state == ST_SELECT)) begin
            aborted <= 1'b0;
        end else if (abort_now) begin
            aborted <= 1'b1;
        end
    end

    // Per-region fault flags: set on abort, cleared by a successful repair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_o <= '0;
        end else begin
            for (int i = 0; i < N_REGIONS; i++) begin
                if (abort_now && (sel == IW'(i))) begin
                    fault_o[i] <= 1'b1;
                end else if (clr_use[i]) begin
                    fault_o[i] <= 1'b0;
                end
            end
        end
    end

    assign copy_req_o    = (state == ST_COPY);
    assign restore_req_o = (state == ST_RESTORE);
    assign heat_en_o     = in_heat && temp_ok_i;
    assign erase_en_o    = heat_en_o && (sel_kind == KIND_NVM);
    assign busy_o        = (state != ST_IDLE);
    assign region_o      = sel;
endmodule

// File: rtl/heal_maint_chk.sv
// Module: property checker for the maintenance controller, bound to the top.
// Assumes: observes ports only, plus one local register of the idle inputs.
module heal_maint_chk #(
    parameter int N_REGIONS = 4,
    parameter int IW        = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_REGIONS-1:0] region_idle_i,
    input logic                 temp_ok_i,
    input logic                 copy_req_o,
    input logic                 copy_done_i,
    input logic                 restore_req_o,
    input logic                 restore_done_i,
    input logic [IW-1:0]        region_o,
    input logic                 heat_en_o,
    input logic                 erase_en_o,
    input logic                 busy_o
);
    logic [N_REGIONS-1:0] idle_q;

    // Idle inputs of the previous cycle, for the selection check.
    always_ff @(posedge clk) begin
        idle_q <= region_idle_i;
    end

    AST_IDLE_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(copy_req_o) |-> idle_q[region_o]); // R2
    AST_COPY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_req_o && !copy_done_i) |=> copy_req_o); // R3
    AST_HEAT_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(heat_en_o) |-> ($past(copy_req_o) && $past(copy_done_i))); // R3
    AST_RESTORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req_o && !restore_done_i) |=> restore_req_o); // R4
    AST_HEAT_ENDS_IN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(heat_en_o) |-> (restore_req_o || !temp_ok_i)); // R4
    AST_ERASE_WITH_HEAT: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en_o |-> heat_en_o); // R7
    AST_HEAT_NEEDS_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        heat_en_o |-> temp_ok_i); // R8
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({copy_req_o, heat_en_o, restore_req_o})); // R9
    AST_BUSY_IN_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_req_o || heat_en_o || restore_req_o) |-> busy_o); // R10
endmodule

bind heal_maint_ctrl heal_maint_chk #(.N_REGIONS(N_REGIONS), .IW(IW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .region_idle_i  (region_idle_i),
    .temp_ok_i      (temp_ok_i),
    .copy_req_o     (copy_req_o),
    .copy_done_i    (copy_done_i),
    .restore_req_o  (restore_req_o),
    .restore_done_i (restore_done_i),
    .region_o       (region_o),
    .heat_en_o      (heat_en_o),
    .erase_en_o     (erase_en_o),
    .busy_o         (busy_o)
);

// File: tb/heal_maint_ctrl_test.sv
// Bench: models the data mover, sensors and regions; checks ports against the requirements.
module heal_maint_ctrl_test;
    localparam int N    = 4;
    localparam int POLL = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] idle = '1;
    logic [N-1:0] aging = '0;
    logic [N-1:0] usev = '0;
    logic         temp_ok = 1'b1;
    logic         copy_req, copy_done = 1'b0;
    logic         restore_req, restore_done = 1'b0;
    logic [1:0]   region;
    logic         heat_en, erase_en, busy;
    logic [N-1:0] fault;

    int tests = 0;
    int fails = 0;
    int early_heat = 0;
    int heat_late = 0;
    int busy_bad = 0;

    // Vector table: {region[1:0], expected heat length[4:0], expected erase}
    localparam logic [7:0] VEC [4] = '{
        {2'd0, 5'd6, 1'b0},
        {2'd1, 5'd3, 1'b0},
        {2'd2, 5'd3, 1'b0},
        {2'd3, 5'd3, 1'b1}
    };

    heal_maint_ctrl uut (
        .clk(clk), .rst_n(rst_n), .region_idle_i(idle), .aging_i(aging), .use_i(usev),
        .temp_ok_i(temp_ok), .copy_req_o(copy_req), .copy_done_i(copy_done),
        .restore_req_o(restore_req), .restore_done_i(restore_done), .region_o(region),
        .heat_en_o(heat_en), .erase_en_o(erase_en), .busy_o(busy), .fault_o(fault)
    );

    always #10 clk = ~clk;

    // Record one check; print a FAIL line on mismatch.
    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Serve one repair as data mover and sensor model.
    task automatic serve(input int tmo, input int cdly, input int drop_at, input bit drop_aging,
                         output int rg, output int hlen, output bit er, output bit ok,
                         output int lat);
        int w;
        ok = 1'b0; rg = -1; hlen = 0; er = 1'b0; lat = 0;
        w = 0;
        while (!copy_req && w < tmo) begin @(negedge clk); w++; end
        lat = w;
        if (!copy_req) return;
        rg = int'(region);
        if (!busy) busy_bad++;
        if (drop_aging) aging[rg] = 1'b0;
        for (int k = 0; k < cdly; k++) begin
            if (heat_en) early_heat++;
            @(negedge clk);
        end
        if (heat_en) early_heat++;
        copy_done = 1'b1;
        @(negedge clk);
        copy_done = 1'b0;
        while (heat_en && hlen < 100) begin
            hlen++;
            er |= erase_en;
            if (hlen == drop_at) begin
                temp_ok = 1'b0;
                #1;
                if (heat_en) heat_late++;
                break;
            end
            @(negedge clk);
        end
        w = 0;
        while (!restore_req && w < 10) begin @(negedge clk); w++; end
        if (!restore_req) return;
        if (!busy) busy_bad++;
        restore_done = 1'b1;
        @(negedge clk);
        restore_done = 1'b0;
        w = 0;
        while (busy && w < 10) begin @(negedge clk); w++; end
        ok = !busy;
    endtask

    // Watch for copy requests over a window; returns how many cycles had one.
    task automatic quiet(input int cyc, output int seen);
        seen = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (copy_req) seen++;
        end
    endtask

    // Issue n usage strobes on one region.
    task automatic pulse_use(input int r, input int n);
        for (int k = 0; k < n; k++) begin
            usev[r] = 1'b1;
            @(negedge clk);
            usev[r] = 1'b0;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int rg, hl, lat, seen;
        bit er, ok;
        int seq [3];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "busy after reset", busy, 0);
        chk("R10", "outputs after reset", {copy_req, restore_req, heat_en, erase_en}, 0);
        chk("R10", "fault after reset", fault, 0);

        // R1: no trigger, no repair
        quiet(40, seen);
        chk("R1", "copy without trigger", seen, 0);

        // Table walk: one aging-triggered repair per region
        for (int v = 0; v < 4; v++) begin
            int r;
            r = int'(VEC[v][7:6]);
            aging[r] = 1'b1;
            serve(60, 3, -1, 1'b1, rg, hl, er, ok, lat);
            chk("R1", "scheduling latency within POLL+3", int'(lat <= POLL + 3), 1);
            chk("R9", "region served", rg, r);
            chk("R6", "heat pulse length", hl, int'(VEC[v][5:1]));
            chk("R7", "erase with heat", int'(er), int'(VEC[v][0]));
            chk("R4", "restore completed and idle", int'(ok), 1);
        end

        // R2: busy region waits, then is served once idle
        idle[1] = 1'b0;
        aging[1] = 1'b1;
        quiet(40, seen);
        chk("R2", "no repair of non-idle region", seen, 0);
        idle[1] = 1'b1;
        serve(60, 1, -1, 1'b1, rg, hl, er, ok, lat);
        chk("R2", "served after going idle", rg, 1);

        // R5: usage threshold and clear
        pulse_use(2, 9);
        quiet(30, seen);
        chk("R5", "no repair below interval", seen, 0);
        pulse_use(2, 1);
        serve(60, 1, -1, 1'b0, rg, hl, er, ok, lat);
        chk("R5", "repair at interval", rg, 2);
        pulse_use(2, 9);
        quiet(30, seen);
        chk("R5", "counter cleared by repair", seen, 0);

        // R8: temperature drop mid-pulse, then retry
        aging[0] = 1'b1;
        serve(60, 2, 2, 1'b1, rg, hl, er, ok, lat);
        chk("R8", "aborted pulse length", hl, 2);
        chk("R8", "heater off in same cycle", heat_late, 0);
        chk("R8", "restore still ran", int'(ok), 1);
        chk("R8", "fault flag set", int'(fault[0]), 1);
        temp_ok = 1'b1;
        serve(60, 1, -1, 1'b1, rg, hl, er, ok, lat);
        chk("R8", "retry of faulted region", rg, 0);
        chk("R8", "retry full length", hl, 6);
        chk("R8", "fault cleared by success", int'(fault[0]), 0);

        // R9: two regions held pending are served in rotation
        aging[0] = 1'b1;
        aging[2] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            serve(60, 1, -1, 1'b0, rg, hl, er, ok, lat);
            seq[k] = rg;
        end
        chk("R9", "first served is 0 or 2", int'(seq[0] == 0 || seq[0] == 2), 1);
        chk("R9", "second differs from first", int'(seq[1] != seq[0] && (seq[1] == 0 || seq[1] == 2)), 1);
        chk("R9", "third returns to first", seq[2], seq[0]);
        aging = '0;
        for (int k = 0; k < 3; k++) serve(30, 1, -1, 1'b0, rg, hl, er, ok, lat);

        // R3 and R10 summaries over the whole run
        chk("R3", "heater before copy done", early_heat, 0);
        chk("R10", "busy low during repair", busy_bad, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule